// File: doc/BRIEF.md
# CAN Receive Filter Routing and Buffer Status

This block follows the identifier-comparison stage of a CAN receiver. When that stage reports an accepted frame, it supplies the number of the filter that matched and the frame identifier. The block holds two small per-filter tables. The first selects which acceptance mask each filter compares under. The second names the message buffer that receives the frames the filter accepts. The mask choice for the reported filter is returned in the same cycle, so the comparison stage can use it directly.

For every accepted frame the block checks a per-buffer occupancy flag. If the target buffer is empty, the block raises a one-cycle store strobe carrying the buffer index and identifier, and it marks the buffer occupied. If the buffer is already occupied, the frame is dropped and an overflow flag is raised for that buffer. Software clears the flags by writing zeros.

The host sees a single 16-register address space. A control bit selects which half of that space is visible: the filter tables or the buffer flags. The control register itself is visible in both halves.

Top module: `can_rx_route`

## Requirements
- R1: After reset every table entry, every occupancy flag, every overflow flag and the window bit are 0, and `store_en` is 0.
- R2: Address 0 is the control register and is reachable in either window. Bit 0 is the window bit (0 = status window, 1 = configuration window). Every other bit reads 0.
- R3: With the window at 1, address 1 holds the mask choices for filters 0–7 and address 2 holds those for filters 8–15. Filter k uses bits [2*(k mod 8)+1 : 2*(k mod 8)].
- R4: With the window at 1, addresses 3, 4, 5 and 6 hold the buffer pointers for filters 0–3, 4–7, 8–11 and 12–15. Filter k uses bits [4*(k mod 4)+3 : 4*(k mod 4)].
- R5: With the window at 0, address 1 shows the occupancy flags of buffers 0–15 and address 2 those of buffers 16–31. Address 3 shows the overflow flags of buffers 0–15 and address 4 those of buffers 16–31. Buffer n sits at bit n mod 16.
- R6: A read of an address that is not mapped in the current window returns 0. A write to such an address changes nothing.
- R7: `mask_idx` combinationally shows the mask choice of filter `hit_filt`. `mask_none` is 1 exactly when that choice is the reserved code 3, which means an exact identifier match is required.
- R8: A hit whose target buffer is empty produces, on the next cycle, `store_en` = 1 for exactly one cycle. `store_buf` carries the filter's pointer zero-extended to 5 bits and `store_id` carries `hit_id`. The buffer's occupancy flag is set.
- R9: A hit whose target buffer is occupied produces no `store_en`. It sets that buffer's overflow flag and leaves the occupancy flag at 1.
- R10: A host write to a flag register clears each flag whose data bit is 0 and leaves each flag whose data bit is 1. Overflow flags otherwise stay set.
- R11: If a hit sets a flag in the same cycle that a host write clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Accepted-frame strobe from the comparison stage |
| hit_filt | input | 4 | Index of the matching filter |
| hit_id | input | 29 | Identifier of the accepted frame |
| mask_idx | output | 2 | Mask choice of filter `hit_filt` |
| mask_none | output | 1 | The mask choice is the reserved code 3 (exact match) |
| store_en | output | 1 | One-cycle write strobe for the buffer memory |
| store_buf | output | 5 | Target buffer index of the write |
| store_id | output | 29 | Identifier that goes with the write |
| reg_addr | input | 4 | Host register address |
| reg_we | input | 1 | Host write strobe |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data (combinational) |

## Verification
A vector table sends hits through filters that share a buffer, filters with distinct buffers, and a filter that has never been programmed. This tells apart per-filter pointer lookup, buffer aliasing between filters, and the default route to buffer 0. Repeated hits to a buffer that is already occupied separate the store path from the drop-and-overflow path. Each vector also checks the mask lookup, including the reserved code. Directed steps then write to addresses outside the current window, use patterned clears that mix zeros and ones, and drive a hit together with a host clear in the same cycle, so that the two writers to each flag are told apart.

// File: rtl/can_rt_pkg.sv
`timescale 1ns/1ps
package can_rt_pkg;
    // Window selector values held in the control register
    typedef enum logic {
        WIN_STATUS = 1'b0,
        WIN_CONFIG = 1'b1
    } win_e;

    // Control register and the first table/flag register of each window
    localparam int unsigned CTRL_ADDR = 0;
    localparam int unsigned CFG_BASE  = 1;
    localparam int unsigned STAT_BASE = 1;
endpackage

// File: rtl/can_rt_cfg.sv
`timescale 1ns/1ps
module can_rt_cfg #(
    parameter int unsigned NFILT  = 16,
    parameter int unsigned PTR_W  = 4,
    parameter int unsigned MSEL_W = 2,
    parameter int unsigned REG_W  = 16,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned BASE   = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     win_on,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [REG_W-1:0]         wdata,
    input  logic [$clog2(NFILT)-1:0] lk_filt,
    output logic [MSEL_W-1:0]        lk_mask,
    output logic [PTR_W-1:0]         lk_ptr,
    output logic [REG_W-1:0]         rdata
);
    localparam int unsigned MS_PER  = REG_W / MSEL_W;
    localparam int unsigned PT_PER  = REG_W / PTR_W;
    localparam int unsigned MS_REGS = (NFILT + MS_PER - 1) / MS_PER;
    localparam int unsigned PT_REGS = (NFILT + PT_PER - 1) / PT_PER;
    localparam int unsigned PT_BASE = BASE + MS_REGS;

    typedef struct packed {
        logic [MS_REGS-1:0][REG_W-1:0] ms;
        logic [PT_REGS-1:0][REG_W-1:0] pt;
    } cfg_t;

    cfg_t cfg_q, cfg_d;

    // Register images, host side
    always_comb begin
        cfg_d = cfg_q;
        rdata = '0;
        for (int r = 0; r < int'(MS_REGS); r++) begin
            if (win_on && addr == ADDR_W'(BASE + r)) begin
                rdata = cfg_q.ms[r];
                if (wr_en) cfg_d.ms[r] = wdata;
            end
        end
        for (int r = 0; r < int'(PT_REGS); r++) begin
            if (win_on && addr == ADDR_W'(PT_BASE + r)) begin
                rdata = cfg_q.pt[r];
                if (wr_en) cfg_d.pt[r] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // Per-filter view of the packed registers
    logic [MSEL_W-1:0] msel_f [NFILT];
    logic [PTR_W-1:0]  ptr_f  [NFILT];

    for (genvar k = 0; k < int'(NFILT); k++) begin : g_filt
        assign msel_f[k] = cfg_q.ms[k / MS_PER][(k % MS_PER) * MSEL_W +: MSEL_W];
        assign ptr_f[k]  = cfg_q.pt[k / PT_PER][(k % PT_PER) * PTR_W +: PTR_W];
    end

    assign lk_mask = msel_f[lk_filt];
    assign lk_ptr  = ptr_f[lk_filt];

    // Tables move only on a host write inside the configuration window
    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_on && wr_en) |=> $stable(cfg_q));
endmodule

// File: rtl/can_rt_stat.sv
`timescale 1ns/1ps
module can_rt_stat #(
    parameter int unsigned NBUF   = 32,
    parameter int unsigned PTR_W  = 4,
    parameter int unsigned REG_W  = 16,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned ID_W   = 29,
    parameter int unsigned BASE   = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     win_on,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [REG_W-1:0]         wdata,
    input  logic                     hit_valid,
    input  logic [PTR_W-1:0]         hit_ptr,
    input  logic [ID_W-1:0]          hit_id,
    output logic                     store_en,
    output logic [$clog2(NBUF)-1:0]  store_buf,
    output logic [ID_W-1:0]          store_id,
    output logic [REG_W-1:0]         rdata
);
    localparam int unsigned BUF_W   = $clog2(NBUF);
    localparam int unsigned ST_REGS = NBUF / REG_W;
    localparam int unsigned OV_BASE = BASE + ST_REGS;

    typedef struct packed {
        logic [NBUF-1:0]  full;
        logic [NBUF-1:0]  ovf;
        logic             st_en;
        logic [BUF_W-1:0] st_buf;
        logic [ID_W-1:0]  st_id;
    } stat_t;

    stat_t st_q, st_d;
    logic [BUF_W-1:0] tgt;

    assign tgt = BUF_W'(hit_ptr);

    always_comb begin
        st_d       = st_q;
        st_d.st_en = 1'b0;
        rdata      = '0;
        // host side first: read, and clear-by-zero
        for (int r = 0; r < int'(ST_REGS); r++) begin
            if (win_on && addr == ADDR_W'(BASE + r)) begin
                rdata = st_q.full[r*REG_W +: REG_W];
                if (wr_en) st_d.full[r*REG_W +: REG_W] = st_q.full[r*REG_W +: REG_W] & wdata;
            end
            if (win_on && addr == ADDR_W'(OV_BASE + r)) begin
                rdata = st_q.ovf[r*REG_W +: REG_W];
                if (wr_en) st_d.ovf[r*REG_W +: REG_W] = st_q.ovf[r*REG_W +: REG_W] & wdata;
            end
        end
        // hardware set comes later so it overrides a same-cycle clear
        if (hit_valid) begin
            if (st_q.full[tgt]) begin
                st_d.ovf[tgt] = 1'b1;
            end else begin
                st_d.full[tgt] = 1'b1;
                st_d.st_en     = 1'b1;
                st_d.st_buf    = tgt;
                st_d.st_id     = hit_id;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign store_en  = st_q.st_en;
    assign store_buf = st_q.st_buf;
    assign store_id  = st_q.st_id;

    assert_store_marks_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.st_en |-> st_q.full[st_q.st_buf]);

    assert_store_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_valid |=> !st_q.st_en);

    assert_drop_on_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && st_q.full[tgt]) |=> (!st_q.st_en && st_q.ovf[$past(tgt)]));

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_on && wr_en) |=> ((st_q.ovf & $past(st_q.ovf)) == $past(st_q.ovf)));
endmodule

// File: rtl/can_rx_route.sv
`timescale 1ns/1ps
module can_rx_route #(
    parameter int unsigned NFILT  = 16,
    parameter int unsigned NBUF   = 32,
    parameter int unsigned PTR_W  = 4,
    parameter int unsigned MSEL_W = 2,
    parameter int unsigned REG_W  = 16,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned ID_W   = 29
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hit_valid,
    input  logic [$clog2(NFILT)-1:0] hit_filt,
    input  logic [ID_W-1:0]          hit_id,
    output logic [MSEL_W-1:0]        mask_idx,
    output logic                     mask_none,
    output logic                     store_en,
    output logic [$clog2(NBUF)-1:0]  store_buf,
    output logic [ID_W-1:0]          store_id,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic                     reg_we,
    input  logic [REG_W-1:0]         reg_wdata,
    output logic [REG_W-1:0]         reg_rdata
);
    import can_rt_pkg::*;

    localparam int unsigned STAT_TOP = STAT_BASE + 2 * (NBUF / REG_W) - 1;

    typedef struct packed {
        win_e win;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    logic [REG_W-1:0] ctl_rd, cfg_rd, st_rd;
    logic [PTR_W-1:0] route_ptr;
    logic             cfg_on, st_on;

    always_comb begin
        ctl_d  = ctl_q;
        ctl_rd = '0;
        if (reg_addr == ADDR_W'(CTRL_ADDR)) begin
            ctl_rd[0] = ctl_q.win;
            if (reg_we) ctl_d.win = win_e'(reg_wdata[0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{win: WIN_STATUS};
        else        ctl_q <= ctl_d;
    end

    assign cfg_on = (ctl_q.win == WIN_CONFIG);
    assign st_on  = (ctl_q.win == WIN_STATUS);

    can_rt_cfg #(
        .NFILT(NFILT), .PTR_W(PTR_W), .MSEL_W(MSEL_W),
        .REG_W(REG_W), .ADDR_W(ADDR_W), .BASE(CFG_BASE)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .win_on(cfg_on), .wr_en(reg_we),
        .addr(reg_addr), .wdata(reg_wdata), .lk_filt(hit_filt),
        .lk_mask(mask_idx), .lk_ptr(route_ptr), .rdata(cfg_rd)
    );

    can_rt_stat #(
        .NBUF(NBUF), .PTR_W(PTR_W), .REG_W(REG_W),
        .ADDR_W(ADDR_W), .ID_W(ID_W), .BASE(STAT_BASE)
    ) u_stat (
        .clk(clk), .rst_n(rst_n), .win_on(st_on), .wr_en(reg_we),
        .addr(reg_addr), .wdata(reg_wdata), .hit_valid(hit_valid),
        .hit_ptr(route_ptr), .hit_id(hit_id), .store_en(store_en),
        .store_buf(store_buf), .store_id(store_id), .rdata(st_rd)
    );

    assign mask_none = (mask_idx == '1);
    assign reg_rdata = ctl_rd | cfg_rd | st_rd;

    assert_oow_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_on && reg_addr > ADDR_W'(STAT_TOP)) |-> reg_rdata == '0);

    assert_ctrl_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(CTRL_ADDR)) |-> reg_rdata[REG_W-1:1] == '0);
endmodule

// File: tb/tb_can_rx_route.sv
`timescale 1ns/1ps
module tb_can_rx_route;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        hit_valid;
    logic [3:0]  hit_filt;
    logic [28:0] hit_id;
    logic [1:0]  mask_idx;
    logic        mask_none;
    logic        store_en;
    logic [4:0]  store_buf;
    logic [28:0] store_id;
    logic [3:0]  reg_addr;
    logic        reg_we;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    can_rx_route dut (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_filt(hit_filt),
        .hit_id(hit_id), .mask_idx(mask_idx), .mask_none(mask_none),
        .store_en(store_en), .store_buf(store_buf), .store_id(store_id),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    // vector: filter(4) id(16) mask(2) store(1) buffer(5)
    localparam int NV = 7;
    localparam logic [27:0] VEC [NV] = '{
        {4'd0,  16'h0101, 2'd1, 1'b1, 5'd3},
        {4'd1,  16'h0202, 2'd2, 1'b1, 5'd7},
        {4'd5,  16'h0303, 2'd3, 1'b0, 5'd0},
        {4'd15, 16'h0404, 2'd2, 1'b1, 5'd15},
        {4'd2,  16'h0505, 2'd0, 1'b1, 5'd0},
        {4'd7,  16'h0606, 2'd0, 1'b0, 5'd0},
        {4'd15, 16'h0707, 2'd2, 1'b0, 5'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic hrd(input string req, input logic [3:0] a, input logic [15:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, 32'(reg_rdata), 32'(exp));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; hit_valid = 1'b0; hit_filt = '0; hit_id = '0;
        reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1 chk("R1 store_en", 32'(store_en), 0);
        for (int a = 0; a < 7; a++) hrd("R1 status window", 4'(a), 16'h0000);

        // R6 out-of-window write and unmapped read
        hwr(4'd5, 16'hABCD);
        hrd("R6 unmapped read", 4'd5, 16'h0000);
        hrd("R6 unmapped read hi", 4'd7, 16'h0000);

        // R2 control register
        hwr(4'd0, 16'hFFFF);
        hrd("R2 ctrl", 4'd0, 16'h0001);
        for (int a = 1; a < 7; a++) hrd("R1 config window", 4'(a), 16'h0000);

        // R3 / R4 program and read back
        hwr(4'd1, 16'h0C09);
        hwr(4'd2, 16'h8000);
        hwr(4'd3, 16'h0073);
        hwr(4'd4, 16'h0030);
        hwr(4'd6, 16'hF000);
        hrd("R3 msel 0-7", 4'd1, 16'h0C09);
        hrd("R3 msel 8-15", 4'd2, 16'h8000);
        hrd("R4 ptr 0-3", 4'd3, 16'h0073);
        hrd("R4 ptr 4-7", 4'd4, 16'h0030);
        hrd("R6 ptr 8-11 untouched", 4'd5, 16'h0000);
        hrd("R4 ptr 12-15", 4'd6, 16'hF000);
        hwr(4'd0, 16'h0000);
        hrd("R2 ctrl back", 4'd0, 16'h0000);

        // vector walk: R7 lookup, R8 store, R9 drop
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            chk("R8 pulse idle", 32'(store_en), 0);
            hit_valid = 1'b1;
            hit_filt  = VEC[i][27:24];
            hit_id    = 29'(VEC[i][23:8]);
            #1;
            chk("R7 mask_idx", 32'(mask_idx), 32'(VEC[i][7:6]));
            chk("R7 mask_none", 32'(mask_none), 32'(VEC[i][7:6] == 2'd3));
            @(negedge clk);
            hit_valid = 1'b0;
            #1;
            if (VEC[i][5]) begin
                chk("R8 store_en", 32'(store_en), 1);
                chk("R8 store_buf", 32'(store_buf), 32'(VEC[i][4:0]));
                chk("R8 store_id", 32'(store_id), 32'(VEC[i][23:8]));
            end else begin
                chk("R9 dropped", 32'(store_en), 0);
            end
        end

        // R5 flag readback
        hrd("R5 full 0-15", 4'd1, 16'h8089);
        hrd("R5 full 16-31", 4'd2, 16'h0000);
        hrd("R9 ovf 0-15", 4'd3, 16'h8009);
        hrd("R5 ovf 16-31", 4'd4, 16'h0000);

        // R10 clear by zero
        hwr(4'd1, 16'hFFF7);
        hrd("R10 partial clear", 4'd1, 16'h8081);
        hrd("R10 ovf untouched", 4'd3, 16'h8009);
        hwr(4'd3, 16'h0000);
        hrd("R10 ovf cleared", 4'd3, 16'h0000);
        hwr(4'd1, 16'h0000);
        hrd("R10 full cleared", 4'd1, 16'h0000);

        // R11 set beats a same-cycle clear
        @(negedge clk);
        hit_valid = 1'b1; hit_filt = 4'd0; hit_id = 29'h0ABC;
        reg_addr = 4'd1; reg_wdata = 16'h0000; reg_we = 1'b1;
        @(negedge clk);
        hit_valid = 1'b0; reg_we = 1'b0;
        #1;
        chk("R11 store_en", 32'(store_en), 1);
        chk("R11 store_buf", 32'(store_buf), 3);
        hrd("R11 full kept", 4'd1, 16'h0008);
        hrd("R11 ovf clear", 4'd3, 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule